// File: doc/BRIEF.md
# Multiplexed Four-Digit Hexadecimal Display Scanner

This block drives a row of four seven-segment digits whose segment lines are wired in common. It shows one digit at a time and steps through them quickly enough that the eye sees all four lit together. A step divider counts system clock cycles. With the default terminal count of 208333 cycles on a 50 MHz clock it produces a digit-advance tick of about 240 Hz, so each digit is refreshed at about 60 Hz.

On each tick a small index register moves to the next digit. The 4-bit slice of the 16-bit input value that belongs to that digit goes through a full hexadecimal font, so the letters A to F can be shown as well as the digits 0 to 9. The font output and the one-hot digit enable are captured in an output register. Both the segment lines and the digit enables are active-low, which suits common-anode wiring.

The reset input is asynchronous and active-low. Its release passes through a two-stage synchronizer before the divider, the index and the output register leave reset.

Top module: `segscan_top`

## Requirements
- R1: While `rst_n` is low, `dig_n` reads 4'b1111 and `seg_n` reads 7'b1111111 (all dark). After `rst_n` rises, the outputs stay dark until the third rising clock edge after the release; that edge lights digit 0.
- R2: From the first lit cycle onward, exactly one bit of `dig_n` is low. Digit k is enabled when bit k of `dig_n` is 0.
- R3: While digit k is enabled, `seg_n` shows the font pattern of `value[4k+3:4k]`, so digit 0 shows bits 3:0 and digit 3 shows bits 15:12.
- R4: Each digit stays enabled for exactly `STEP_CYCLES` clock cycles before the next digit takes over, and the internal step counter never reaches `STEP_CYCLES`.
- R5: Digits are enabled in the order 0, 1, 2, 3 and then 0 again.
- R6: `seg_n` bit 0 drives segment a, bit 1 b, bit 2 c, bit 3 d, bit 4 e, bit 5 f and bit 6 g; a 0 lights the segment. The lit sets are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all, 9=abcdfg, A=abcefg, b=cdefg, C=adef, d=bcdeg, E=adefg, F=aefg.
- R7: A change of `value` reaches `seg_n` on the next rising clock edge and does not change which digit is enabled or how long it stays enabled.
- R8: A reset asserted in the middle of a scan darkens the outputs at once. After release the scan restarts at digit 0, and digit 0 then gets a full `STEP_CYCLES` window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| value | input | 16 | Four hexadecimal nibbles; nibble k goes to digit k |
| seg_n | output | 7 | Active-low segment lines a..g in bits 0..6 |
| dig_n | output | 4 | Active-low digit enables, bit k for digit k |

## Verification
The bench builds the block with `STEP_CYCLES` set to 5 in place of the default 208333. With that setting each digit window lasts only a few cycles, so the bench can measure exact window lengths, watch several complete wraps from digit 3 back to digit 0, and test the reset during a scan, all in a few hundred cycles. `NUM_DIGITS` stays at 4. Every one of the sixteen font codes is applied through the real segment path.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

  localparam int NIB_W = 4;
  localparam int SEG_W = 7;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Width of a counter that holds 0 .. n-1 (at least one bit).
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/segscan_rst_sync.sv
module segscan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;

endmodule

// File: rtl/segscan_divider.sv
module segscan_divider #(
  parameter  int STEP_CYCLES = 208333,
  localparam int CNT_W       = segscan_pkg::cnt_width(STEP_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_q_n,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST_CNT);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = wrap;
  assign cnt  = cnt_q;

endmodule

// File: rtl/segscan_index.sv
module segscan_index #(
  parameter  int NUM_DIGITS = 4,
  localparam int IDX_W      = segscan_pkg::cnt_width(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             step_en,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    if (idx_q == LAST_IDX) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      idx_q <= '0;
    end else if (step_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/segscan_font.sv
module segscan_font
  import segscan_pkg::*;
(
  input  nib_t code,
  output seg_t lit      // active-high, bit 0 = a ... bit 6 = g
);

  always_comb begin
    unique case (code)
      4'h0:    lit = 7'b0111111;
      4'h1:    lit = 7'b0000110;
      4'h2:    lit = 7'b1011011;
      4'h3:    lit = 7'b1001111;
      4'h4:    lit = 7'b1100110;
      4'h5:    lit = 7'b1101101;
      4'h6:    lit = 7'b1111101;
      4'h7:    lit = 7'b0000111;
      4'h8:    lit = 7'b1111111;
      4'h9:    lit = 7'b1101111;
      4'hA:    lit = 7'b1110111;
      4'hB:    lit = 7'b1111100;
      4'hC:    lit = 7'b0111001;
      4'hD:    lit = 7'b1011110;
      4'hE:    lit = 7'b1111001;
      default: lit = 7'b1110001;
    endcase
  end

endmodule

// File: rtl/segscan_top.sv
module segscan_top
  import segscan_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int STEP_CYCLES = 208333
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_DIGITS*NIB_W-1:0] value,
  output logic [SEG_W-1:0]            seg_n,
  output logic [NUM_DIGITS-1:0]       dig_n
);

  localparam int IDX_W = cnt_width(NUM_DIGITS);
  localparam int CNT_W = cnt_width(STEP_CYCLES);

  logic             rst_q_n;
  logic             step_tick;
  logic [CNT_W-1:0] div_cnt;
  logic [IDX_W-1:0] idx_q;

  nib_t                  nib_arr [NUM_DIGITS];
  nib_t                  cur_nib;
  seg_t                  cur_lit;
  seg_t                  seg_d;
  seg_t                  seg_q;
  logic [NUM_DIGITS-1:0] dig_d;
  logic [NUM_DIGITS-1:0] dig_q;

  segscan_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  segscan_divider #(
    .STEP_CYCLES (STEP_CYCLES)
  ) u_divider (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .tick    (step_tick),
    .cnt     (div_cnt)
  );

  segscan_index #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_index (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .step_en (step_tick),
    .idx     (idx_q)
  );

  // Slice the input word into one nibble per digit and decode the enables.
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    assign nib_arr[k] = value[k*NIB_W +: NIB_W];
    assign dig_d[k]   = (idx_q != IDX_W'(k));
  end

  assign cur_nib = nib_arr[idx_q];

  segscan_font u_font (
    .code (cur_nib),
    .lit  (cur_lit)
  );

  assign seg_d = ~cur_lit;

  // Output stage: glitch-free active-low drive, dark while in reset.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      seg_q <= '1;
      dig_q <= '1;
    end else begin
      seg_q <= seg_d;
      dig_q <= dig_d;
    end
  end

  assign seg_n = seg_q;
  assign dig_n = dig_q;

endmodule

// File: rtl/segscan_chk.sv
module segscan_chk #(
  parameter  int NUM_DIGITS  = 4,
  parameter  int STEP_CYCLES = 208333,
  localparam int IDX_W       = segscan_pkg::cnt_width(NUM_DIGITS),
  localparam int CNT_W       = segscan_pkg::cnt_width(STEP_CYCLES)
) (
  input logic                  clk,
  input logic                  rst_q_n,
  input logic                  tick,
  input logic [IDX_W-1:0]      idx,
  input logic [CNT_W-1:0]      cnt,
  input logic [NUM_DIGITS-1:0] dig_n
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  logic [IDX_W-1:0] idx_prev;
  logic             lit_seen;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      idx_prev <= '0;
      lit_seen <= 1'b0;
    end else begin
      idx_prev <= idx;
      lit_seen <= 1'b1;
    end
  end

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_q_n)
    lit_seen |-> $countones(~dig_n) == 1);                              // R2

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_q_n)
    cnt < CNT_W'(STEP_CYCLES));                                         // R4

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !tick |=> $stable(idx));                                            // R4

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tick && idx == LAST_IDX) |=> idx == '0);                           // R5

  AST_IDX_NEXT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tick && idx != LAST_IDX) |=> idx == $past(idx) + 1'b1);            // R5

  AST_ENABLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_q_n)
    lit_seen |-> dig_n[idx_prev] == 1'b0);                              // R3

endmodule

bind segscan_top segscan_chk #(
  .NUM_DIGITS  (NUM_DIGITS),
  .STEP_CYCLES (STEP_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .tick    (step_tick),
  .idx     (idx_q),
  .cnt     (div_cnt),
  .dig_n   (dig_n)
);

// File: tb/tb_segscan_top.sv
`timescale 1ns/1ps
module tb_segscan_top;

  localparam int STEP = 5;

  logic        clk;
  logic        rst_n;
  logic [15:0] value;
  logic [6:0]  seg_n;
  logic [3:0]  dig_n;

  int total;
  int fails;
  int cyc;

  segscan_top #(
    .NUM_DIGITS  (4),
    .STEP_CYCLES (STEP)
  ) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .value (value),
    .seg_n (seg_n),
    .dig_n (dig_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Active-low segment pattern, bit 0 = a ... bit 6 = g (R6 table).
  function automatic logic [6:0] exp_seg(input logic [3:0] c);
    logic [6:0] on;
    case (c)
      4'h0: on = 7'h3F; 4'h1: on = 7'h06; 4'h2: on = 7'h5B; 4'h3: on = 7'h4F;
      4'h4: on = 7'h66; 4'h5: on = 7'h6D; 4'h6: on = 7'h7D; 4'h7: on = 7'h07;
      4'h8: on = 7'h7F; 4'h9: on = 7'h6F; 4'hA: on = 7'h77; 4'hB: on = 7'h7C;
      4'hC: on = 7'h39; 4'hD: on = 7'h5E; 4'hE: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  function automatic int pat_to_idx(input logic [3:0] p);
    case (p)
      4'b1110: return 0;
      4'b1101: return 1;
      4'b1011: return 2;
      4'b0111: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called on the negedge that starts a window; returns its length and
  // leaves time at the negedge that starts the next window.
  task automatic measure_window(output int len);
    logic [3:0] pat;
    pat = dig_n;
    len = 1;
    forever begin
      @(negedge clk);
      if (dig_n != pat) break;
      len++;
    end
  endtask

  task automatic wait_lit(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (dig_n == 4'hF);
  endtask

  task automatic wait_window_start();
    logic [3:0] prev;
    prev = dig_n;
    forever begin
      @(negedge clk);
      if (dig_n != prev) break;
      prev = dig_n;
    end
  endtask

  task automatic t_reset();
    int waited;
    value = 16'hFACE;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dig_n == 4'hF, "R1 reset dig_n", 32'(dig_n), 32'hF);
    chk(seg_n == 7'h7F, "R1 reset seg_n", 32'(seg_n), 32'h7F);
    rst_n = 1'b1;
    wait_lit(waited);
    chk(waited == 3, "R1 release latency", 32'(waited), 32'd3);
    chk(dig_n == 4'b1110, "R1 first lit digit", 32'(dig_n), 32'hE);
  endtask

  // Called at the first lit negedge.
  task automatic t_scan();
    int len;
    for (int w = 0; w < 8; w++) begin
      int k;
      k = pat_to_idx(dig_n);
      chk($countones(~dig_n) == 1, "R2 one digit", 32'(dig_n), 32'(~(4'b1 << (w % 4))));
      chk(k == (w % 4), "R5 scan order", 32'(k), 32'(w % 4));
      chk(seg_n == exp_seg(value[4*(w%4) +: 4]), "R3 nibble on digit",
          32'(seg_n), 32'(exp_seg(value[4*(w%4) +: 4])));
      measure_window(len);
      chk(len == STEP, "R4 window length", 32'(len), 32'(STEP));
    end
  endtask

  task automatic t_font();
    for (int c = 0; c < 16; c++) begin
      value = {4{4'(c)}};
      @(negedge clk);
      chk(seg_n == exp_seg(4'(c)), "R6 font code", 32'(seg_n), 32'(exp_seg(4'(c))));
    end
  endtask

  task automatic t_latency();
    logic [3:0]  pat;
    logic [6:0]  old_seg;
    logic [15:0] nv;
    int k;
    value = 16'h1234;
    wait_window_start();
    pat     = dig_n;
    k       = pat_to_idx(pat);
    old_seg = seg_n;
    nv      = value ^ (16'h8 << (4 * k));
    value   = nv;
    #1;
    chk(seg_n == old_seg, "R7 no same-cycle change", 32'(seg_n), 32'(old_seg));
    @(negedge clk);
    chk(seg_n == exp_seg(nv[4*k +: 4]), "R7 next-edge update",
        32'(seg_n), 32'(exp_seg(nv[4*k +: 4])));
    chk(dig_n == pat, "R7 digit unchanged", 32'(dig_n), 32'(pat));
  endtask

  task automatic t_midreset();
    int waited;
    int len;
    value = 16'hFACE;
    while (dig_n != 4'b1011) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(dig_n == 4'hF, "R8 dark at once", 32'(dig_n), 32'hF);
    chk(seg_n == 7'h7F, "R8 segments dark", 32'(seg_n), 32'h7F);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_lit(waited);
    chk(dig_n == 4'b1110, "R8 restart at digit 0", 32'(dig_n), 32'hE);
    chk(seg_n == exp_seg(4'hE), "R8 digit 0 nibble", 32'(seg_n), 32'(exp_seg(4'hE)));
    measure_window(len);
    chk(len == STEP, "R8 full first window", 32'(len), 32'(STEP));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    total = 0;
    fails = 0;
    cyc   = 0;
    rst_n = 1'b0;
    value = '0;
    t_reset();
    t_scan();
    t_font();
    t_latency();
    t_midreset();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule